// File: doc/BRIEF.md
# Packet Stream Output Formatter

This block takes the corrected byte stream of a forward-error-corrected transport receiver and places it on the output pins. Each packet has 188 payload bytes followed by 16 check bytes. The packet can leave the block in one of two forms:

- **Parallel:** one byte per byte-clock period on an 8-bit bus.
- **Serial:** one bit per byte-clock period on data line 0, most significant bit first.

Alongside the data the block produces three framing signals:

- a byte clock;
- a packet clock that tells payload from check bytes;
- a flag that marks a packet the decoder could not correct.

Every signal polarity is programmable. The byte clock can also be silenced during check bytes. Output enables let the pad ring tri-state the interface.

The upstream decoder presents a byte with a one-cycle `in_valid` strobe:

- `in_sop` marks byte 0 of a packet.
- `in_uncorr`, sampled with `in_sop`, tells whether the packet is uncorrectable.
- In parallel mode a byte is shown for 2 clock cycles, so strobes must be at least 2 cycles apart.
- In serial mode a byte is shown for 16 cycles, so strobes must be at least 16 cycles apart.

The format settings are captured at each packet start.

Top module: `pkt_out_fmt`

## Requirements
- R1: `out_pkt_clk` is 1 while a payload byte (index 0..187) is shown and 0 while a check byte (index 188..203) is shown. When the captured `cfg_pkt_inv` is 1, both levels are inverted.
- R2: `out_err` equals the `in_uncorr` value captured with `in_sop`, for every byte of that packet. When the captured `cfg_err_inv` is 1, it is inverted.
- R3: In an uncorrectable packet, byte index 1 leaves with bit 7 set to 1. All other bytes, and every byte of a correctable packet, leave unchanged.
- R4: In parallel mode, a byte accepted at clock edge T is on `out_data` from edge T to edge T+2. `out_byte_clk` is at the start level during the first cycle and at the opposite level during the second. With `cfg_clk_rise`=0 the start level is 1, giving a falling edge mid-byte. With `cfg_clk_rise`=1 the start level is 0, giving a rising edge mid-byte.
- R5: When the captured `cfg_par_mask` is 1, `out_byte_clk` stays 0 throughout check bytes. Payload bytes are clocked normally.
- R6: In serial mode a byte takes 16 cycles. Bit 7-k is on `out_data[0]` during cycles 2k and 2k+1. `out_byte_clk` follows the R4 pattern for each bit. `out_data[7:1]` is 0. `out_oe_data` is 8'h01.
- R7: One cycle after `cfg_hiz` is 1, `out_oe_ctl` is 0 and `out_oe_data` is 0. With `cfg_hiz` 0, `out_oe_ctl` is 1 and `out_oe_data` is 8'hFF in parallel mode.
- R8: The settings `cfg_serial`, `cfg_clk_rise`, `cfg_pkt_inv`, `cfg_err_inv` and `cfg_par_mask` are captured only with `in_sop`. Changing them inside a packet has no effect until the next packet start.
- R9: A strobed byte is ignored and leaves every output unchanged in either of two cases: it arrives before any `in_sop`, or it arrives after the 204th byte of a packet without a new `in_sop`.
- R10: After reset:
  - `out_data`, `out_byte_clk`, `out_pkt_clk` and `out_err` are 0;
  - `out_oe_ctl` is 1;
  - `out_oe_data` is 8'hFF.
- R11: `out_pkt_clk` and `out_err` change only in the cycle after an accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_byte | input | 8 | Corrected byte |
| in_valid | input | 1 | Byte strobe |
| in_sop | input | 1 | Byte is the first of a packet |
| in_uncorr | input | 1 | Packet is uncorrectable (sampled with `in_sop`) |
| cfg_serial | input | 1 | 1 selects serial output |
| cfg_clk_rise | input | 1 | Byte-clock edge at which data is valid: 0 falling, 1 rising |
| cfg_pkt_inv | input | 1 | Inverts the packet clock |
| cfg_err_inv | input | 1 | Makes the error flag active low |
| cfg_par_mask | input | 1 | Holds the byte clock low during check bytes |
| cfg_hiz | input | 1 | Tri-states all outputs |
| out_data | output | 8 | Data bus; serial data appears on bit 0 |
| out_oe_data | output | 8 | Per-line output enable for `out_data` |
| out_oe_ctl | output | 1 | Output enable for the byte clock, packet clock and error flag |
| out_byte_clk | output | 1 | Byte clock (bit clock in serial mode) |
| out_pkt_clk | output | 1 | Packet clock: payload/check indicator |
| out_err | output | 1 | Uncorrectable-packet flag |

## Verification
Packets of random content are sent with random format settings. Correctable and uncorrectable packets are mixed, so the forced bit 7 on byte 1 is checked against untouched bytes in the same position. Settings are re-randomized inside packets; a formatter that does not capture at the packet start shows up as a wrong level on the bytes that follow. Directed cases cover the following:
- strobes before the first packet start and after the last check byte, which separate a counter that stops from one that wraps;
- an output-disable window in the middle of a serial packet;
- masked and unmasked check bytes under both edge settings.

// File: rtl/pkt_out_fmt_pkg.sv
package pkt_out_fmt_pkg;
  // Per-packet output format, captured at packet start
  typedef struct packed {
    logic serial;
    logic rise;
    logic pkt_inv;
    logic err_inv;
    logic mask;
  } fmt_mode_t;
endpackage

// File: rtl/pkt_seq.sv
// Tracks byte position inside a packet, captures the format and the
// uncorrectable status at packet start, and patches byte 1 when needed.
module pkt_seq
  import pkt_out_fmt_pkg::*;
#(
  parameter int DATA_BYTES   = 188,
  parameter int PARITY_BYTES = 16,
  parameter int BYTE_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_uncorr,
  input  fmt_mode_t         mode_in,
  output logic              ld,
  output logic [BYTE_W-1:0] ld_byte,
  output logic              ld_par,
  output fmt_mode_t         ld_mode,
  output logic              ld_unc
);
  localparam int TOTAL = DATA_BYTES + PARITY_BYTES;
  localparam int IDX_W = $clog2(TOTAL);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

  logic [IDX_W-1:0] cnt, cur_idx;
  logic             active, unc_q;
  fmt_mode_t        mode_q;

  always_comb begin
    cur_idx = in_sop ? '0 : cnt;
    ld      = in_valid && (in_sop || active);
    ld_mode = in_sop ? mode_in : mode_q;
    ld_unc  = in_sop ? in_uncorr : unc_q;
    ld_par  = cur_idx >= IDX_W'(DATA_BYTES);
    ld_byte = in_byte;
    if (ld_unc && cur_idx == IDX_W'(1))
      ld_byte[BYTE_W-1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
      unc_q  <= 1'b0;
      mode_q <= '0;
    end else if (ld) begin
      cnt    <= cur_idx + IDX_W'(1);
      active <= cur_idx != LAST_IDX;
      if (in_sop) begin
        mode_q <= mode_in;
        unc_q  <= in_uncorr;
      end
    end
  end
endmodule

// File: rtl/pkt_shaper.sv
// Turns each accepted byte into a 2-phase (parallel) or 16-phase (serial)
// pin waveform with registered outputs.
module pkt_shaper
  import pkt_out_fmt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [BYTE_W-1:0] ld_byte,
  input  logic              ld_par,
  input  fmt_mode_t         ld_mode,
  input  logic              ld_unc,
  input  logic              hiz,
  output logic [BYTE_W-1:0] out_data,
  output logic [BYTE_W-1:0] out_oe_data,
  output logic              out_oe_ctl,
  output logic              out_byte_clk,
  output logic              out_pkt_clk,
  output logic              out_err
);
  localparam int PH_W  = $clog2(2 * BYTE_W);
  localparam int BIT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sh;
  logic [PH_W-1:0]   phase, nph, last;
  logic [BIT_W-1:0]  bit_sel;
  logic              running, serial_q, rise_q, mask_q, par_q, serial_now;

  function automatic logic clk_level(input logic odd, input logic rise,
                                     input logic masked);
    return masked ? 1'b0 : (odd ? rise : !rise);
  endfunction

  always_comb begin
    last       = serial_q ? PH_W'(2 * BYTE_W - 1) : PH_W'(1);
    nph        = phase + PH_W'(1);
    bit_sel    = BIT_W'(BYTE_W - 1) - nph[PH_W-1:1];
    serial_now = ld ? ld_mode.serial : serial_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh           <= '0;
      phase        <= '0;
      running      <= 1'b0;
      serial_q     <= 1'b0;
      rise_q       <= 1'b0;
      mask_q       <= 1'b0;
      par_q        <= 1'b0;
      out_data     <= '0;
      out_byte_clk <= 1'b0;
      out_pkt_clk  <= 1'b0;
      out_err      <= 1'b0;
      out_oe_ctl   <= 1'b1;
      out_oe_data  <= '1;
    end else begin
      out_oe_ctl  <= !hiz;
      out_oe_data <= hiz ? '0 : (serial_now ? BYTE_W'(1) : '1);
      if (ld) begin
        sh           <= ld_byte;
        phase        <= '0;
        running      <= 1'b1;
        serial_q     <= ld_mode.serial;
        rise_q       <= ld_mode.rise;
        mask_q       <= ld_mode.mask;
        par_q        <= ld_par;
        out_pkt_clk  <= !ld_par ^ ld_mode.pkt_inv;
        out_err      <= ld_unc ^ ld_mode.err_inv;
        out_byte_clk <= clk_level(1'b0, ld_mode.rise, ld_mode.mask && ld_par);
        out_data     <= ld_mode.serial ? BYTE_W'(ld_byte[BYTE_W-1]) : ld_byte;
      end else if (running) begin
        phase        <= nph;
        running      <= nph != last;
        out_byte_clk <= clk_level(nph[0], rise_q, mask_q && par_q);
        if (serial_q)
          out_data <= BYTE_W'(sh[bit_sel]);
      end
    end
  end
endmodule

// File: rtl/pkt_out_fmt.sv
module pkt_out_fmt
  import pkt_out_fmt_pkg::*;
#(
  parameter int DATA_BYTES   = 188,
  parameter int PARITY_BYTES = 16,
  parameter int BYTE_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_uncorr,
  input  logic              cfg_serial,
  input  logic              cfg_clk_rise,
  input  logic              cfg_pkt_inv,
  input  logic              cfg_err_inv,
  input  logic              cfg_par_mask,
  input  logic              cfg_hiz,
  output logic [BYTE_W-1:0] out_data,
  output logic [BYTE_W-1:0] out_oe_data,
  output logic              out_oe_ctl,
  output logic              out_byte_clk,
  output logic              out_pkt_clk,
  output logic              out_err
);
  fmt_mode_t         mode_in, ld_mode;
  logic              ld, ld_par, ld_unc;
  logic [BYTE_W-1:0] ld_byte;

  assign mode_in = '{serial: cfg_serial, rise: cfg_clk_rise,
                     pkt_inv: cfg_pkt_inv, err_inv: cfg_err_inv,
                     mask: cfg_par_mask};

  pkt_seq #(
    .DATA_BYTES(DATA_BYTES), .PARITY_BYTES(PARITY_BYTES), .BYTE_W(BYTE_W)
  ) u_seq (
    .clk(clk), .rst(rst), .in_byte(in_byte), .in_valid(in_valid),
    .in_sop(in_sop), .in_uncorr(in_uncorr), .mode_in(mode_in),
    .ld(ld), .ld_byte(ld_byte), .ld_par(ld_par), .ld_mode(ld_mode),
    .ld_unc(ld_unc)
  );

  pkt_shaper #(.BYTE_W(BYTE_W)) u_shaper (
    .clk(clk), .rst(rst), .ld(ld), .ld_byte(ld_byte), .ld_par(ld_par),
    .ld_mode(ld_mode), .ld_unc(ld_unc), .hiz(cfg_hiz),
    .out_data(out_data), .out_oe_data(out_oe_data), .out_oe_ctl(out_oe_ctl),
    .out_byte_clk(out_byte_clk), .out_pkt_clk(out_pkt_clk), .out_err(out_err)
  );
endmodule

// File: rtl/pkt_out_fmt_chk.sv
module pkt_out_fmt_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              cfg_hiz,
  input logic [BYTE_W-1:0] out_data,
  input logic [BYTE_W-1:0] out_oe_data,
  input logic              out_oe_ctl,
  input logic              out_pkt_clk,
  input logic              out_err
);
  AST_HIZ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    cfg_hiz |=> (!out_oe_ctl && out_oe_data == '0)); // R7

  AST_FLAGS_BYTE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_pkt_clk) && $stable(out_err))); // R11

  AST_PAR_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && out_oe_data == '1) |=> $stable(out_data)); // R4

  AST_SERIAL_UPPER_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($countones(out_oe_data) == 1) |-> (out_data[BYTE_W-1:1] == '0)); // R6

  AST_OE_SHAPE: assert property (@(posedge clk) disable iff (rst)
    ($countones(out_oe_data) == 0 || out_oe_data == BYTE_W'(1) ||
     out_oe_data == '1)); // R6
endmodule

bind pkt_out_fmt pkt_out_fmt_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/pkt_out_fmt_tb.sv
module pkt_out_fmt_tb;
  localparam int DATA_BYTES = 188;
  localparam int TOTAL      = 204;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_byte = '0;
  logic       in_valid = 1'b0, in_sop = 1'b0, in_uncorr = 1'b0;
  logic       cfg_serial = 1'b0, cfg_clk_rise = 1'b0, cfg_pkt_inv = 1'b0;
  logic       cfg_err_inv = 1'b0, cfg_par_mask = 1'b0, cfg_hiz = 1'b0;
  logic [7:0] out_data, out_oe_data;
  logic       out_oe_ctl, out_byte_clk, out_pkt_clk, out_err;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model state
  bit l_ser, l_rise, l_pinv, l_einv, l_mask, l_unc, b_active;
  int b_idx;

  always #2.5 clk = ~clk;

  pkt_out_fmt u_dut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (byte %0d)", tag, act, exp, b_idx);
    end
  endtask

  function automatic logic [7:0] exp_oe_data();
    return cfg_hiz ? 8'h00 : (l_ser ? 8'h01 : 8'hFF);
  endfunction

  task automatic check_outputs(input logic [7:0] eb, input bit par, input int p);
    logic exp_clk;
    logic [7:0] exp_d;
    exp_clk = (l_mask && par) ? 1'b0 : ((p % 2) ? l_rise : !l_rise);
    exp_d   = l_ser ? {7'b0, eb[7 - p / 2]} : eb;
    chk((b_idx == 1 && l_unc) ? "R3" : (l_ser ? "R6" : "R4"), out_data, exp_d);
    chk((l_mask && par) ? "R5" : (l_ser ? "R6" : "R4"), {7'b0, out_byte_clk}, {7'b0, exp_clk});
    chk("R1,R8,R11", {7'b0, out_pkt_clk}, {7'b0, (!par) ^ l_pinv});
    chk("R2,R8,R11", {7'b0, out_err}, {7'b0, l_unc ^ l_einv});
    chk("R7", out_oe_data, exp_oe_data());
    chk("R7", {7'b0, out_oe_ctl}, {7'b0, !cfg_hiz});
  endtask

  // Called at a negative edge; returns at the negative edge of the last phase.
  task automatic send_byte(input logic [7:0] b, input bit sop, input bit unc);
    logic [7:0] snap_d, eb;
    logic [3:0] snap_f;
    bit par;
    int span;
    if (!sop && !b_active) begin
      // R9: byte outside a packet must be ignored
      snap_d = out_data;
      snap_f = {out_byte_clk, out_pkt_clk, out_err, out_oe_ctl};
      in_byte = b; in_valid = 1'b1; in_sop = 1'b0; in_uncorr = unc;
      @(negedge clk);
      in_valid = 1'b0;
      for (int k = 0; k < 2; k++) begin
        chk("R9", out_data, snap_d);
        chk("R9", {4'b0, out_byte_clk, out_pkt_clk, out_err, out_oe_ctl}, {4'b0, snap_f});
        @(negedge clk);
      end
      return;
    end
    if (sop) begin
      l_ser = cfg_serial; l_rise = cfg_clk_rise; l_pinv = cfg_pkt_inv;
      l_einv = cfg_err_inv; l_mask = cfg_par_mask; l_unc = unc;
      b_idx = 0;
    end
    eb   = b | ((l_unc && b_idx == 1) ? 8'h80 : 8'h00);
    par  = b_idx >= DATA_BYTES;
    span = l_ser ? 16 : 2;
    in_byte = b; in_valid = 1'b1; in_sop = sop; in_uncorr = unc;
    for (int p = 0; p < span; p++) begin
      @(negedge clk);
      if (p == 0) begin in_valid = 1'b0; in_sop = 1'b0; end
      check_outputs(eb, par, p);
    end
    b_idx++;
    b_active = b_idx < TOTAL;
  endtask

  task automatic rand_cfg();
    cfg_serial = 1'($urandom % 4 == 0); cfg_clk_rise = 1'($urandom);
    cfg_pkt_inv = 1'($urandom); cfg_err_inv = 1'($urandom);
    cfg_par_mask = 1'($urandom);
  endtask

  // One packet; R8: settings re-randomized inside the packet when mid_change is set
  task automatic send_packet(input bit unc, input bit mid_change, input bit hiz_window);
    for (int i = 0; i < TOTAL; i++) begin
      if (mid_change && i > 0 && $urandom % 16 == 0) rand_cfg();
      if (hiz_window) cfg_hiz = (i >= 100 && i < 110);
      send_byte(8'($urandom), i == 0, unc);
    end
    cfg_hiz = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    b_active = 1'b0; b_idx = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10", out_data, 8'h00);
    chk("R10", {4'b0, out_byte_clk, out_pkt_clk, out_err, out_oe_ctl}, 8'h01);
    chk("R10", out_oe_data, 8'hFF);
    // R9: bytes before any packet start
    for (int k = 0; k < 3; k++) send_byte(8'($urandom), 1'b0, 1'b0);
    // parallel, falling-edge, correctable
    cfg_serial = 0; cfg_clk_rise = 0; cfg_pkt_inv = 0; cfg_err_inv = 0; cfg_par_mask = 0;
    send_packet(1'b0, 1'b0, 1'b0);
    // parallel, rising-edge, inverted flags, masked, uncorrectable, mid-packet changes (R8)
    cfg_clk_rise = 1; cfg_pkt_inv = 1; cfg_err_inv = 1; cfg_par_mask = 1;
    send_packet(1'b1, 1'b1, 1'b0);
    // R9: extra byte after the last check byte
    send_byte(8'hA5, 1'b0, 1'b1);
    // serial, masked, uncorrectable, with an output-disable window (R7)
    cfg_serial = 1; cfg_clk_rise = 1'($urandom); cfg_pkt_inv = 0; cfg_err_inv = 0; cfg_par_mask = 1;
    send_packet(1'b1, 1'b0, 1'b1);
    // serial unmasked correctable, then back to parallel
    cfg_par_mask = 0;
    send_packet(1'b0, 1'b1, 1'b0);
    // random packets
    for (int n = 0; n < 4; n++) begin
      rand_cfg();
      send_packet(1'($urandom), 1'b1, 1'($urandom));
    end
    send_byte(8'h3C, 1'b0, 1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule